// File: doc/BRIEF.md
# Four-Lane Striped Fletcher Accumulator

This block is the front end of a wide Fletcher-style checksum engine. Each clock it takes one 128-bit beat that holds four consecutive 32-bit words of the stream. It stripes the stream across four independent lanes, so lane j sees words 4i+j. Each lane runs the four-level running-sum cascade on the words it receives. Every level is 64 bits wide and wraps modulo 2^64.

When the beat flagged as last is accepted, the sixteen lane sums that include that beat are registered to the output, and `res_valid` pulses for one cycle. The lanes then restart from zero for the next stream. A separate block merges the sixteen partial sums with fixed weights into the final checksum. That merge depends only on the lane position and never on the buffer length.

Streams must hold a whole number of beats. The stream cannot be padded with zero words, because a zero word still advances the second, third and fourth sums of its lane.

Top module: `stripe_fletcher_acc`

## Requirements
- R1: While `rst` is high, `beat_ready` and `res_valid` are 0 and `res_sums` is all zero. `beat_ready` is 1 from the first clock edge after `rst` falls.
- R2: Bits [32j+31:32j] of `beat_data` feed lane j, for j = 0..3. Bits [31:0] carry the earliest word of the group of four.
- R3: Each word is zero-extended to 64 bits before it is added. A word with bit 31 set adds a positive value.
- R4: For each accepted beat, every lane updates in this order: s1 += word, s2 += new s1, s3 += new s2, s4 += new s3. Each step uses the value just updated.
- R5: All sums wrap modulo 2^64.
- R6: A cycle with `beat_valid` low changes no lane sum, and its `beat_last` and `beat_data` are ignored.
- R7: `res_valid` is 1 in exactly the cycle after a beat with `beat_last` high is accepted, and 0 in every other cycle.
- R8: After a last beat is accepted, all lane sums restart from zero. A new stream can begin on the very next beat.
- R9: `res_sums` changes only when `res_valid` rises. Otherwise it holds its value.
- R10: `res_sums[(4j+k)*64 +: 64]` holds sum level k of lane j, with k = 0 for s1, 1 for s2, 2 for s3 and 3 for s4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | Beat present on `beat_data` |
| beat_ready | output | 1 | Block accepts a beat this cycle |
| beat_data | input | 128 | Four 32-bit words, lane 0 in the low bits |
| beat_last | input | 1 | Final beat of the stream |
| res_valid | output | 1 | One-cycle pulse: `res_sums` newly loaded |
| res_sums | output | 1024 | Sixteen 64-bit lane sums, layout per R10 |

## Verification
The tests use the following streams:
- A single beat of four distinct words shows whether the lanes are mapped to the right bit fields and output slots.
- Words with bit 31 set separate zero extension from sign extension.
- A multi-beat stream of varied words checks the order of the cascade updates, including that each step uses the freshly updated value.
- A stream broken by idle cycles, which carry junk data and a raised last flag, shows whether invalid cycles leak into the sums.
- Back-to-back single-beat streams check that the lanes clear at once and that the pulse repeats correctly.
- A long all-ones stream drives the fourth sum past 2^64 to confirm the wrap.

// File: rtl/fl_stripe_pkg.sv
package fl_stripe_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned SUM_W_DEF  = 64;
  localparam int unsigned LEVELS     = 4;
endpackage

// File: rtl/fl_lane_cascade.sv
module fl_lane_cascade #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SUM_W  = 64,
  parameter int unsigned LEVELS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step,
  input  logic                      restart,
  input  logic [WORD_W-1:0]         word,
  output logic [LEVELS*SUM_W-1:0]   nxt_sums,
  output logic [SUM_W-1:0]          lvl0_q
);
  logic [SUM_W-1:0] acc_q [LEVELS];
  logic [SUM_W-1:0] acc_d [LEVELS];

  // cascade: each level adds the freshly updated level below it
  always_comb begin
    acc_d[0] = acc_q[0] + {{(SUM_W-WORD_W){1'b0}}, word};
    for (int k = 1; k < LEVELS; k++) begin
      acc_d[k] = acc_q[k] + acc_d[k-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      assign nxt_sums[g*SUM_W +: SUM_W] = acc_d[g];
      always_ff @(posedge clk) begin
        if (rst || (step && restart)) acc_q[g] <= '0;
        else if (step)                acc_q[g] <= acc_d[g];
      end
    end
  endgenerate

  assign lvl0_q = acc_q[0];
endmodule

// File: rtl/fl_result_reg.sv
module fl_result_reg #(
  parameter int unsigned W = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         vld,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      dout <= '0;
    end else begin
      vld <= load;
      if (load) dout <= din;
    end
  end
endmodule

// File: rtl/stripe_fletcher_acc.sv
module stripe_fletcher_acc #(
  parameter int unsigned LANES  = fl_stripe_pkg::LANES_DEF,
  parameter int unsigned WORD_W = fl_stripe_pkg::WORD_W_DEF,
  parameter int unsigned SUM_W  = fl_stripe_pkg::SUM_W_DEF
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          beat_valid,
  output logic                                          beat_ready,
  input  logic [LANES*WORD_W-1:0]                       beat_data,
  input  logic                                          beat_last,
  output logic                                          res_valid,
  output logic [LANES*fl_stripe_pkg::LEVELS*SUM_W-1:0]  res_sums
);
  localparam int unsigned LEVELS = fl_stripe_pkg::LEVELS;
  localparam int unsigned LANE_W = LEVELS * SUM_W;
  localparam int unsigned ALL_W  = LANES * LANE_W;

  logic             fire;
  logic [ALL_W-1:0] all_next;
  logic [SUM_W-1:0] lane_lvl0 [LANES];
  logic [SUM_W-1:0] lane0_s1;

  always_ff @(posedge clk) begin
    if (rst) beat_ready <= 1'b0;
    else     beat_ready <= 1'b1;
  end

  assign fire = beat_valid && beat_ready;

  genvar j;
  generate
    for (j = 0; j < LANES; j++) begin : g_lane
      fl_lane_cascade #(
        .WORD_W (WORD_W),
        .SUM_W  (SUM_W),
        .LEVELS (LEVELS)
      ) u_lane (
        .clk      (clk),
        .rst      (rst),
        .step     (fire),
        .restart  (beat_last),
        .word     (beat_data[j*WORD_W +: WORD_W]),
        .nxt_sums (all_next[j*LANE_W +: LANE_W]),
        .lvl0_q   (lane_lvl0[j])
      );
    end
  endgenerate

  assign lane0_s1 = lane_lvl0[0];

  fl_result_reg #(.W(ALL_W)) u_res (
    .clk  (clk),
    .rst  (rst),
    .load (fire && beat_last),
    .din  (all_next),
    .vld  (res_valid),
    .dout (res_sums)
  );
endmodule

// File: rtl/stripe_fletcher_acc_chk.sv
module stripe_fletcher_acc_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SUM_W  = 64,
  parameter int unsigned ALL_W  = 1024,
  parameter int unsigned DW     = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic [DW-1:0]    beat_data,
  input logic             beat_last,
  input logic             res_valid,
  input logic [ALL_W-1:0] res_sums,
  input logic [SUM_W-1:0] lane0_s1
);
  // R1: reset quiets the handshake and result flag
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!beat_ready && !res_valid));

  // R7: pulse follows an accepted last beat
  a_r7_pulse_after_last: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && beat_last) |=> res_valid);

  // R7: no pulse without an accepted last beat
  a_r7_no_stray_pulse: assert property (@(posedge clk) disable iff (rst)
    !(beat_valid && beat_ready && beat_last) |=> !res_valid);

  // R9: result holds unless freshly loaded
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_sums));

  // R3, R4: lane 0 first level adds the zero-extended word
  a_r4_lane0_step: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && !beat_last) |=>
      lane0_s1 == $past(lane0_s1) + {{(SUM_W-WORD_W){1'b0}}, $past(beat_data[WORD_W-1:0])});

  // R6: idle cycles leave lane state alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !beat_valid |=> $stable(lane0_s1));

  // R8: lanes restart after the last beat
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ready && beat_last) |=> lane0_s1 == '0);
endmodule

bind stripe_fletcher_acc stripe_fletcher_acc_chk #(
  .WORD_W (WORD_W),
  .SUM_W  (SUM_W),
  .ALL_W  (LANES*fl_stripe_pkg::LEVELS*SUM_W),
  .DW     (LANES*WORD_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_data  (beat_data),
  .beat_last  (beat_last),
  .res_valid  (res_valid),
  .res_sums   (res_sums),
  .lane0_s1   (lane0_s1)
);

// File: tb/stripe_fletcher_acc_tb.sv
`timescale 1ns/1ps
module stripe_fletcher_acc_tb;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          beat_valid = 1'b0;
  logic          beat_ready;
  logic [127:0]  beat_data = '0;
  logic          beat_last = 1'b0;
  logic          res_valid;
  logic [1023:0] res_sums;

  stripe_fletcher_acc u_dut (
    .clk        (clk),
    .rst        (rst),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_data  (beat_data),
    .beat_last  (beat_last),
    .res_valid  (res_valid),
    .res_sums   (res_sums)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit live  = 0;
  bit done  = 0;
  string cur_req = "R1";

  longint unsigned m   [4][4];
  longint unsigned eo  [4][4];
  bit              exp_valid = 0;

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // one clock: drive at negedge, model updates after the edge
  task automatic cycle(bit v, logic [127:0] d, bit l);
    bit rdy;
    @(negedge clk);
    beat_valid = v; beat_data = d; beat_last = l;
    rdy = beat_ready;
    if (v) chk(rdy == 1'b1, "R1", "ready when beat offered", 64'(rdy), 64'd1);
    @(posedge clk);
    exp_valid = 0;
    if (v && rdy) begin
      for (int j = 0; j < 4; j++) begin
        longint unsigned w = {32'd0, d[32*j +: 32]};
        m[j][0] += w; m[j][1] += m[j][0]; m[j][2] += m[j][1]; m[j][3] += m[j][2];
      end
      if (l) begin
        eo = m;
        exp_valid = 1;
        foreach (m[a, b]) m[a][b] = 0;
      end
    end
  endtask

  // compare outputs against the model every cycle
  always @(negedge clk) begin
    if (live && !rst) begin
      bit same = 1;
      longint unsigned fa = 0, fe = 0;
      chk(res_valid == exp_valid, "R7", "res_valid", 64'(res_valid), 64'(exp_valid));
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++)
          if (same && res_sums[(4*j+k)*64 +: 64] != eo[j][k]) begin
            same = 0; fa = res_sums[(4*j+k)*64 +: 64]; fe = eo[j][k];
          end
      chk(same, cur_req, "res_sums (R10 layout)", fa, fe);
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired in %s actual=hung expected=finished", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (m[a, b]) begin m[a][b] = 0; eo[a][b] = 0; end
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(beat_ready == 0, "R1", "ready in reset", 64'(beat_ready), 0);
    chk(res_valid == 0, "R1", "valid in reset", 64'(res_valid), 0);
    chk(res_sums == '0, "R1", "sums in reset", res_sums[63:0], 0);
    rst = 0;
    live = 1;
    @(posedge clk);
    @(negedge clk);
    chk(beat_ready == 1, "R1", "ready after reset", 64'(beat_ready), 1);

    // R2, R10: distinct words in one beat
    cur_req = "R2";
    cycle(1, {32'h0000_0044, 32'h0000_0033, 32'h0000_0022, 32'h0000_0011}, 1);
    cycle(0, '0, 0);

    // R3: high bit set words must not sign-extend
    cur_req = "R3";
    cycle(1, {32'hFFFF_FFFF, 32'h8000_0000, 32'hC000_0001, 32'h8000_0001}, 0);
    cycle(1, {32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFE}, 1);
    cycle(0, '0, 0);

    // R4: multi-beat stream, cascade order
    cur_req = "R4";
    for (int b = 0; b < 7; b++)
      cycle(1, {32'(b*97+4), 32'(b*13+3), 32'(b*1001+2), 32'(b*7+1)}, b == 6);
    cycle(0, '0, 0);

    // R6: bubbles with junk data and last raised
    cur_req = "R6";
    cycle(1, {4{32'h0000_0101}}, 0);
    cycle(0, {4{32'hDEAD_BEEF}}, 1);
    cycle(0, {4{32'h1234_5678}}, 1);
    cycle(1, {32'd9, 32'd8, 32'd7, 32'd6}, 0);
    cycle(0, {4{32'hFFFF_FFFF}}, 1);
    cycle(1, {32'd5, 32'd4, 32'd3, 32'd2}, 1);
    cycle(0, '0, 0);

    // R8: back-to-back single-beat streams
    cur_req = "R8";
    cycle(1, {32'd40, 32'd30, 32'd20, 32'd10}, 1);
    cycle(1, {32'd4, 32'd3, 32'd2, 32'd1}, 1);
    cycle(1, {32'd400, 32'd300, 32'd200, 32'd100}, 0);
    cycle(1, {32'd1, 32'd1, 32'd1, 32'd1}, 1);

    // R9: long idle stretch, result must hold
    cur_req = "R9";
    repeat (10) cycle(0, {4{32'hA5A5_A5A5}}, 0);

    // R5: long all-ones stream wraps the fourth level
    cur_req = "R5";
    for (int b = 0; b < 2000; b++)
      cycle(1, {4{32'hFFFF_FFFF}}, b == 1999);
    cycle(0, '0, 0);
    // closed-form check of lane 0 level 3: W*C(n+3,4) mod 2^64
    begin
      longint unsigned n = 2000;
      longint unsigned c4 = (n * (n+1) * (n+2) * (n+3)) / 24;
      longint unsigned ex = c4 * 64'h0000_0000_FFFF_FFFF;
      chk(res_sums[3*64 +: 64] == ex, "R5", "wrapped lane0 level3", res_sums[3*64 +: 64], ex);
    end
    cycle(0, '0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule